// File: doc/BRIEF.md
# Monochrome Bitmap Video Scanout

This block turns a one-bit-per-pixel bitmap held in dual-port video memory into a monochrome video signal with horizontal and vertical sync. A 512x256 image sits in the centre of an 800x600 raster that runs from a 40 MHz pixel clock. Each 16-bit memory word carries 16 neighbouring pixels of one row, and 32 words in a row make up one image line. The block drives the read address of the memory's second port and takes the returned word one cycle later.

A beam counter walks the raster. While the beam is inside an image row, the block issues the address of the next word two pixel times before the current word runs out. The returned word is loaded into a shift register in the cycle before it is needed, so pixels leave without gaps. Everything outside the image window is black. Pixel and both syncs come out of one register stage, so they stay aligned.

Top module: `framebuf_scanout`

## Requirements
- R1: While rst_ni is low, pix_o, hsync_o and vsync_o are 0. After release the beam starts at column 0 of line 0, and the first edge registers that position.
- R2: A line lasts 1056 clocks (800 visible, 40 front porch, 128 sync, 88 back porch). hsync_o is high for exactly 128 clocks per line, for beam columns 840 to 967.
- R3: A frame lasts 628 lines (600 visible, 1 front porch, 4 sync, 23 back porch). vsync_o is high on all of beam lines 601 to 604 and changes only at a line start.
- R4: pix_o is 0 for every beam position outside columns 144..655 and lines 172..427. This includes all porch and sync intervals.
- R5: Inside the window, the pixel at image column x and row y is bit (15 - x mod 16) of word y*32 + x/16, so bit 15 is the leftmost pixel of each word.
- R6: During image lines, vid_addr_o shows y*32 + k in the cycle where the beam is two columns before the first pixel of word k. The block accepts vid_data_i in the following cycle.
- R7: pix_o, hsync_o and vsync_o all lag the beam position by exactly one clock, with no extra delay for pixels.
- R8: pix_o is never high while hsync_o or vsync_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_addr_o | output | 13 | Word address on the video memory read port |
| vid_data_i | input | 16 | Read data, valid one cycle after its address |
| pix_o | output | 1 | Monochrome pixel, 1 = lit |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |

## Verification
The bound checker watches every cycle for the properties that hold without knowing the memory contents. It checks that no pixel is lit during either sync, that each horizontal pulse is exactly the sync width, that vertical sync moves only while horizontal sync is low, and that every shift-register load follows a fetch by one cycle. Pixel values, bit order, window placement and the exact address issued per word depend on the stored bitmap. Only the bench's directed frames can show these, because they compare every output cycle against a model of the bitmap.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  localparam int unsigned DEF_WORD_W = 16;

  function automatic logic in_span(input int unsigned val, input int unsigned lo,
                                   input int unsigned len);
    return (val >= lo) && (val < lo + len);
  endfunction
endpackage

// File: rtl/fbscan_timing.sv
module fbscan_timing #(
  parameter int unsigned H_VIS  = 800,
  parameter int unsigned H_FP   = 40,
  parameter int unsigned H_SYNC = 128,
  parameter int unsigned H_BP   = 88,
  parameter int unsigned V_VIS  = 600,
  parameter int unsigned V_FP   = 1,
  parameter int unsigned V_SYNC = 4,
  parameter int unsigned V_BP   = 23,
  localparam int unsigned H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int unsigned HCW   = $clog2(H_TOT),
  localparam int unsigned VCW   = $clog2(V_TOT)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [HCW-1:0] h_o,
  output logic [VCW-1:0] v_o,
  output logic           hs_o,
  output logic           vs_o
);
  import fbscan_pkg::*;

  logic [HCW-1:0] h_q;
  logic [VCW-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == HCW'(H_TOT - 1)) begin
      h_q <= '0;
      v_q <= (v_q == VCW'(V_TOT - 1)) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o  = h_q;
  assign v_o  = v_q;
  assign hs_o = in_span(32'(h_q), H_VIS + H_FP, H_SYNC);
  assign vs_o = in_span(32'(v_q), V_VIS + V_FP, V_SYNC);
endmodule

// File: rtl/fbscan_fetch.sv
module fbscan_fetch #(
  parameter int unsigned IMG_W  = 512,
  parameter int unsigned IMG_H  = 256,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned X0     = 144,
  parameter int unsigned Y0     = 172,
  parameter int unsigned HCW    = 11,
  parameter int unsigned VCW    = 10,
  parameter int unsigned AW     = 13,
  localparam int unsigned WPR   = IMG_W / WORD_W,
  localparam int unsigned WL    = $clog2(WORD_W)
) (
  input  logic [HCW-1:0] h_i,
  input  logic [VCW-1:0] v_i,
  output logic [AW-1:0]  addr_o,
  output logic           fetch_o,
  output logic           load_o,
  output logic           win_o
);
  import fbscan_pkg::*;

  logic        row_ok;
  logic [31:0] fx, lx, row;

  // fetch two pixels ahead of word start, load one pixel ahead
  assign row_ok  = in_span(32'(v_i), Y0, IMG_H);
  assign fx      = 32'(h_i) - (X0 - 2);
  assign lx      = 32'(h_i) - (X0 - 1);
  assign row     = 32'(v_i) - Y0;
  assign fetch_o = row_ok && (fx < IMG_W) && (fx[WL-1:0] == '0);
  assign load_o  = row_ok && (lx < IMG_W) && (lx[WL-1:0] == '0);
  assign win_o   = row_ok && in_span(32'(h_i), X0, IMG_W);
  assign addr_o  = AW'(row * WPR + (fx >> WL));
endmodule

// File: rtl/fbscan_serializer.sv
module fbscan_serializer #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              win_i,
  input  logic              hs_i,
  input  logic              vs_i,
  output logic              pix_o,
  output logic              hs_o,
  output logic              vs_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      pix_o <= 1'b0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
    end else begin
      sh_q  <= load_i ? word_i : {sh_q[WORD_W-2:0], 1'b0};
      pix_o <= win_i & sh_q[WORD_W-1];
      hs_o  <= hs_i;
      vs_o  <= vs_i;
    end
  end
endmodule

// File: rtl/framebuf_scanout.sv
module framebuf_scanout #(
  parameter int unsigned IMG_W  = 512,
  parameter int unsigned IMG_H  = 256,
  parameter int unsigned WORD_W = fbscan_pkg::DEF_WORD_W,
  parameter int unsigned H_VIS  = 800,
  parameter int unsigned H_FP   = 40,
  parameter int unsigned H_SYNC = 128,
  parameter int unsigned H_BP   = 88,
  parameter int unsigned V_VIS  = 600,
  parameter int unsigned V_FP   = 1,
  parameter int unsigned V_SYNC = 4,
  parameter int unsigned V_BP   = 23,
  localparam int unsigned X0    = (H_VIS - IMG_W) / 2,
  localparam int unsigned Y0    = (V_VIS - IMG_H) / 2,
  localparam int unsigned AW    = $clog2(IMG_W / WORD_W * IMG_H),
  localparam int unsigned HCW   = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  localparam int unsigned VCW   = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [AW-1:0]     vid_addr_o,
  input  logic [WORD_W-1:0] vid_data_i,
  output logic              pix_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic [HCW-1:0] h_cnt;
  logic [VCW-1:0] v_cnt;
  logic           hs_raw, vs_raw, fetch_hit, load_hit, in_win;

  fbscan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .h_o(h_cnt), .v_o(v_cnt), .hs_o(hs_raw), .vs_o(vs_raw)
  );

  fbscan_fetch #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WORD_W(WORD_W), .X0(X0), .Y0(Y0),
    .HCW(HCW), .VCW(VCW), .AW(AW)
  ) u_fetch (
    .h_i(h_cnt), .v_i(v_cnt), .addr_o(vid_addr_o),
    .fetch_o(fetch_hit), .load_o(load_hit), .win_o(in_win)
  );

  fbscan_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_hit), .word_i(vid_data_i),
    .win_i(in_win), .hs_i(hs_raw), .vs_i(vs_raw),
    .pix_o(pix_o), .hs_o(hsync_o), .vs_o(vsync_o)
  );
endmodule

// File: rtl/framebuf_scanout_chk.sv
module framebuf_scanout_chk #(
  parameter int unsigned H_SYNC = 128,
  localparam int unsigned LW    = $clog2(H_SYNC + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_o,
  input logic hsync_o,
  input logic vsync_o,
  input logic fetch_hit,
  input logic load_hit
);
  logic [LW-1:0] hs_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hs_len <= '0;
    else if (hsync_o) hs_len <= hs_len + 1'b1;
    else              hs_len <= '0;
  end

  assert_blank_in_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o |-> (!hsync_o && !vsync_o));

  assert_hsync_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |-> (hs_len == LW'(H_SYNC)));

  assert_vsync_line_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> !hsync_o);

  assert_load_after_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_hit |-> $past(fetch_hit));
endmodule

bind framebuf_scanout framebuf_scanout_chk #(.H_SYNC(H_SYNC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_o(pix_o), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .fetch_hit(fetch_hit), .load_hit(load_hit)
);

// File: tb/framebuf_scanout_test.sv
`timescale 1ns/1ps
module framebuf_scanout_test;
  localparam int IMG_W = 64, IMG_H = 8, WW = 16;
  localparam int H_VIS = 96, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_VIS = 16, V_FP = 1, V_SYNC = 2, V_BP = 3;
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int X0 = (H_VIS - IMG_W) / 2, Y0 = (V_VIS - IMG_H) / 2;
  localparam int WPR = IMG_W / WW, DEPTH = WPR * IMG_H;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [WW-1:0] rdata;
  logic pix, hs, vs;
  logic [WW-1:0] mem [DEPTH];
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) rdata <= mem[addr];

  framebuf_scanout #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WORD_W(WW),
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .vid_addr_o(addr), .vid_data_i(rdata),
    .pix_o(pix), .hsync_o(hs), .vsync_o(vs)
  );

  function automatic logic exp_pix(int h, int v);
    int x, y;
    if (h < X0 || h >= X0 + IMG_W || v < Y0 || v >= Y0 + IMG_H) return 1'b0;
    x = h - X0;
    y = v - Y0;
    return mem[y * WPR + x / WW][WW - 1 - x % WW];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
    end
  endtask

  task automatic fill(input int sel);
    for (int a = 0; a < DEPTH; a++) begin
      case (sel)
        0: mem[a] = 16'hA5C3 ^ 16'(a * 16'h1357);
        1: mem[a] = 16'hFFFF;
        default: mem[a] = 16'h8001;
      endcase
    end
  endtask

  // one scenario: reset, load bitmap, check one full frame plus part of a line
  task automatic run_frame(input int sel, input string name);
    int e_r2, e_r3, e_r4, e_r5, e_r6, e_r8, last_addr;
    int hp, vp, hc, vc, fx;
    e_r2 = 0; e_r3 = 0; e_r4 = 0; e_r5 = 0; e_r6 = 0; e_r8 = 0; last_addr = 0;
    @(negedge clk);
    rst_n = 1'b0;
    fill(sel);
    #1;
    chk(pix == 0 && hs == 0 && vs == 0, {"R1 reset outputs ", name},
        {pix, hs, vs}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 1; n <= HT * VT + HT + 37; n++) begin
      @(negedge clk);
      hp = (n - 1) % HT; vp = ((n - 1) / HT) % VT;
      hc = n % HT;       vc = (n / HT) % VT;
      if (n == 1)
        chk(pix == 0 && hs == 0 && vs == 0, {"R1 R7 first position ", name},
            {pix, hs, vs}, 0);
      if (hs != (hp >= H_VIS + H_FP && hp < H_VIS + H_FP + H_SYNC)) e_r2++;
      if (vs != (vp >= V_VIS + V_FP && vp < V_VIS + V_FP + V_SYNC)) e_r3++;
      if (pix != exp_pix(hp, vp)) begin
        if (hp >= X0 && hp < X0 + IMG_W && vp >= Y0 && vp < Y0 + IMG_H) begin
          if (e_r5 == 0) $display("FAIL R5 R7 %s h=%0d v=%0d act=%0b exp=%0b",
                                  name, hp, vp, pix, exp_pix(hp, vp));
          e_r5++;
        end else begin
          if (e_r4 == 0) $display("FAIL R4 %s h=%0d v=%0d act=%0b exp=0",
                                  name, hp, vp, pix);
          e_r4++;
        end
      end
      if (pix && (hs || vs)) e_r8++;
      fx = hc - (X0 - 2);
      if (vc >= Y0 && vc < Y0 + IMG_H && fx >= 0 && fx < IMG_W && fx % WW == 0) begin
        if (int'(addr) != (vc - Y0) * WPR + fx / WW) begin
          if (e_r6 == 0) $display("FAIL R6 %s h=%0d v=%0d act=%0d exp=%0d",
                                  name, hc, vc, addr, (vc - Y0) * WPR + fx / WW);
          e_r6++;
        end
      end
    end
    chk(e_r2 == 0, {"R2 hsync timing ", name}, e_r2, 0);
    chk(e_r3 == 0, {"R3 vsync timing ", name}, e_r3, 0);
    chk(e_r4 == 0, {"R4 blank outside window ", name}, e_r4, 0);
    chk(e_r5 == 0, {"R5 R7 pixel content ", name}, e_r5, 0);
    chk(e_r6 == 0, {"R6 fetch address ", name}, e_r6, 0);
    chk(e_r8 == 0, {"R8 no pixel in sync ", name}, e_r8, 0);
  endtask

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    run_frame(0, "mixed");
    run_frame(1, "solid");
    run_frame(2, "edge-bits");
    chk(pix == 0 || !hs, "R8 final", pix, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    fails++;
    tests++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule